// File: doc/BRIEF.md
# Programmable-Increment Timestamp Counter

This block keeps a free-running 64-bit time value for precision packet timestamping. An 8-bit period and a 24-bit step set its rate. After every period-th clock, the step is added to the counter. The clocks in between leave the counter unchanged. Software usually programs a step that is left-shifted. The upper bits of the counter then count whole nanoseconds, and the lower bits carry a fraction of a nanosecond. A small change to the step therefore trims the rate finely.

A three-register interface serves software. Address 0 is the low half of the time value, address 1 is the high half, and address 2 is the increment configuration. Reading the low half saves the high half into a shadow, so a read of low then high is never torn. Writing the low half only stages the value. Writing the high half then loads both halves in one clock.

Top module: `tstamp_counter`

## Requirements
- R1: After reset, reads of addresses 0, 1 and 2 all return zero.
- R2: The increment register at address 2 reads back exactly what was written. Bits 31:24 are the period and bits 23:0 are the step value.
- R3: Every P-th clock, the counter adds the step value. P is the period field. On the clocks in between, the counter holds its value.
- R4: A period field of zero behaves as a period of one, so the step is added on every clock.
- R5: A write to the increment register does not reset the prescaler or change the count. The period in progress completes with the old step, and the new setting applies from the next boundary.
- R6: A write to address 0 only stages a value and leaves the counter unchanged. A write to address 1 loads {written data, staged value} into the counter in one clock and restarts the prescaler.
- R7: A read of address 0 returns the low half and saves the high half into a shadow. A later read of address 1 returns that shadow, even if the counter has since carried into its high half.
- R8: When the counter passes 2^64 - 1, it wraps modulo 2^64 and needs no special handling.
- R9: With period 1 and step 40<<18, 25 updates advance the nanosecond field (time >> 18) by exactly 1000.
- R10: With period 3 and step 125<<14, 24 clocks advance the nanosecond field (time >> 14) by exactly 1000.
- R11: Read data appears on regRdData in the clock after the read strobe and holds until the next read. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 low, 1 high, 2 increment, 3 unused |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered |

## Verification
The assertions assume the following about the inputs:
- reset is synchronous to clk;
- the address and write data are defined whenever a strobe is high;
- a step can never exceed 2^24, so a drop in the count without a load can only be a wrap.

The bench meets these assumptions. It drives every input on the falling edge and clears both strobes after each access. It keeps the random periods short, so many boundaries fall inside the run, including boundaries that land on the same clock as an increment write or a load.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_TIME_LO = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_TIME_HI = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_INC_CFG = 2'd2;

  // Strobes from control to datapath, one clock wide.
  typedef struct packed {
    logic tick;     // prescaler boundary: add the active step
    logic load;     // write of high half: load {data, staged low}
    logic stageWr;  // write of low half: stage the value
    logic snapLow;  // read of low half: capture high into shadow
    logic rdEn;     // any read: update the read data register
  } tsStrobes_t;

  typedef enum logic [1:0] {
    RD_LOW  = 2'd0,
    RD_HIGH = 2'd1,
    RD_INC  = 2'd2,
    RD_ZERO = 2'd3
  } tsReadSel_e;

endpackage

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
  import tstamp_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int VALUE_W  = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        regWrEn,
  input  logic                        regRdEn,
  input  logic [REG_ADDR_W-1:0]       regAddr,
  input  logic [PERIOD_W+VALUE_W-1:0] incWrData,
  output tsStrobes_t                  strobes,
  output tsReadSel_e                  rdSel,
  output logic [PERIOD_W+VALUE_W-1:0] incCfg,
  output logic [VALUE_W-1:0]          actValue
);

  localparam int INC_W = PERIOD_W + VALUE_W;

  logic [PERIOD_W-1:0] actPeriod;
  logic [PERIOD_W-1:0] preCnt;
  logic [PERIOD_W-1:0] lastIdx;
  logic                wrLow;
  logic                wrHigh;
  logic                wrInc;
  logic                boundary;

  // Address decode
  always_comb begin
    wrLow  = regWrEn && (regAddr == ADDR_TIME_LO);
    wrHigh = regWrEn && (regAddr == ADDR_TIME_HI);
    wrInc  = regWrEn && (regAddr == ADDR_INC_CFG);
    unique case (regAddr)
      ADDR_TIME_LO: rdSel = RD_LOW;
      ADDR_TIME_HI: rdSel = RD_HIGH;
      ADDR_INC_CFG: rdSel = RD_INC;
      default:      rdSel = RD_ZERO;
    endcase
  end

  // A period field of zero behaves like a period of one
  assign lastIdx  = (actPeriod == '0) ? '0 : actPeriod - 1'b1;
  assign boundary = (preCnt == lastIdx);

  always_comb begin
    strobes         = '0;
    strobes.tick    = boundary && !wrHigh;
    strobes.load    = wrHigh;
    strobes.stageWr = wrLow;
    strobes.snapLow = regRdEn && (regAddr == ADDR_TIME_LO);
    strobes.rdEn    = regRdEn;
  end

  // Programmed configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      incCfg <= '0;
    end else if (wrInc) begin
      incCfg <= incWrData;
    end
  end

  // Prescaler and the active copy of the configuration, reloaded at each boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt    <= '0;
      actPeriod <= '0;
      actValue  <= '0;
    end else if (wrHigh) begin
      preCnt <= '0;
    end else if (boundary) begin
      preCnt    <= '0;
      actPeriod <= incCfg[INC_W-1 -: PERIOD_W];
      actValue  <= incCfg[VALUE_W-1:0];
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
    preCnt <= lastIdx);  // R3
  AST_INC_WRITE: assert property (@(posedge clk) disable iff (rst)
    wrInc |=> (incCfg == $past(incWrData)));  // R2
  AST_INC_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (wrInc && !wrHigh && !boundary) |=> (preCnt == $past(preCnt) + 1'b1));  // R5

endmodule

// File: rtl/tstamp_dp.sv
module tstamp_dp
  import tstamp_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int DATA_W  = 32,
  parameter int VALUE_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  tsStrobes_t         strobes,
  input  tsReadSel_e         rdSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  incCfg,
  input  logic [VALUE_W-1:0] actValue,
  output logic [DATA_W-1:0]  rdData
);

  localparam int HI_W = TIME_W - DATA_W;

  logic [TIME_W-1:0] timeReg;
  logic [DATA_W-1:0] stageLow;
  logic [HI_W-1:0]   shadowHi;
  logic [DATA_W-1:0] rdNext;

  // Time counter; overflow wraps modulo 2^TIME_W
  always_ff @(posedge clk) begin
    if (rst) begin
      timeReg <= '0;
    end else if (strobes.load) begin
      timeReg <= {wrData[HI_W-1:0], stageLow};
    end else if (strobes.tick) begin
      timeReg <= timeReg + TIME_W'(actValue);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stageLow <= '0;
    end else if (strobes.stageWr) begin
      stageLow <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowHi <= '0;
    end else if (strobes.snapLow) begin
      shadowHi <= timeReg[TIME_W-1:DATA_W];
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_LOW:  rdNext = timeReg[DATA_W-1:0];
      RD_HIGH: rdNext = DATA_W'(shadowHi);
      RD_INC:  rdNext = incCfg;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strobes.rdEn) begin
      rdData <= rdNext;
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (!strobes.tick && !strobes.load) |=> $stable(timeReg));  // R3
  AST_NO_BACKSTEP: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> ((timeReg >= $past(timeReg)) ||
                       (timeReg < (TIME_W'(1) << VALUE_W))));  // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.snapLow |=> $stable(shadowHi));  // R7
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.stageWr |=> $stable(stageLow));  // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.rdEn |=> $stable(rdData));  // R11

endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter
  import tstamp_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData
);

  localparam int VALUE_W = DATA_W - PERIOD_W;

  tsStrobes_t         strobes;
  tsReadSel_e         rdSel;
  logic [DATA_W-1:0]  incCfg;
  logic [VALUE_W-1:0] actValue;

  tstamp_ctrl #(
    .PERIOD_W(PERIOD_W),
    .VALUE_W (VALUE_W)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .incWrData(regWrData),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .incCfg   (incCfg),
    .actValue (actValue)
  );

  tstamp_dp #(
    .TIME_W (TIME_W),
    .DATA_W (DATA_W),
    .VALUE_W(VALUE_W)
  ) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .incCfg  (incCfg),
    .actValue(actValue),
    .rdData  (regRdData)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.tick, strobes.load}));  // R6

endmodule

// File: tb/test_tstamp_counter.sv
module test_tstamp_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int checks = 0;
  int errors = 0;

  // Reference state, advanced once per clock from the requirements
  logic [63:0] mTime;
  logic [7:0]  mCnt;
  logic [7:0]  mActP;
  logic [23:0] mActV;
  logic [31:0] mInc;
  logic [31:0] mStage;
  logic [31:0] mShadow;
  logic [31:0] mRd;

  always #2 clk = ~clk;

  tstamp_counter i_tstamp_counter (
    .clk      (clk),
    .rst      (rst),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mTime = '0; mCnt = '0; mActP = '0; mActV = '0;
    mInc = '0; mStage = '0; mShadow = '0; mRd = '0;
  endtask

  task automatic modelEdge(input logic wr, input logic rd, input logic [1:0] a,
                           input logic [31:0] d);
    logic [7:0]  lastIdx;
    logic        bnd;
    logic        ld;
    logic [63:0] nTime;
    lastIdx = (mActP == 0) ? 8'd0 : mActP - 8'd1;
    bnd     = (mCnt == lastIdx);
    ld      = wr && (a == 2'd1);
    if (rd) begin
      case (a)
        2'd0: begin mRd = mTime[31:0]; mShadow = mTime[63:32]; end
        2'd1: mRd = mShadow;
        2'd2: mRd = mInc;
        default: mRd = '0;
      endcase
    end
    nTime = ld ? {d, mStage} : (bnd ? mTime + 64'(mActV) : mTime);
    if (ld) begin
      mCnt = '0;
    end else if (bnd) begin
      mCnt  = '0;
      mActP = mInc[31:24];
      mActV = mInc[23:0];
    end else begin
      mCnt = mCnt + 8'd1;
    end
    mTime = nTime;
    if (wr && a == 2'd0) mStage = d;
    if (wr && a == 2'd2) mInc = d;
  endtask

  // Called on a falling edge; returns on the next falling edge
  task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [31:0] d);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = d;
    @(posedge clk);
    modelEdge(wr, rd, a, d);
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d);
  endtask

  task automatic rdReg(input string req, input logic [1:0] a, output logic [31:0] v);
    step(1'b0, 1'b1, a, 32'd0);
    v = regRdData;
    chk(req, 64'(v), 64'(mRd));
  endtask

  task automatic loadTime(input logic [63:0] t);
    wr(2'd0, t[31:0]);
    wr(2'd1, t[63:32]);
  endtask

  task automatic setInc(input logic [7:0] p, input logic [23:0] v);
    wr(2'd2, {p, v});
    idle(300);
  endtask

  task automatic readTime(input string req, output logic [63:0] t);
    logic [31:0] lo;
    logic [31:0] hi;
    rdReg(req, 2'd0, lo);
    rdReg(req, 2'd1, hi);
    t = {hi, lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] t;
    modelReset();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rdReg("R1", 2'd0, v); chk("R1", 64'(v), 64'd0);
    rdReg("R1", 2'd1, v); chk("R1", 64'(v), 64'd0);
    rdReg("R1", 2'd2, v); chk("R1", 64'(v), 64'd0);

    // R2 configuration readback and R11 unused address
    wr(2'd2, 32'h5A12_3456);
    rdReg("R2", 2'd2, v); chk("R2", 64'(v), 64'h5A12_3456);
    rdReg("R11", 2'd3, v); chk("R11", 64'(v), 64'd0);
    idle(3);
    chk("R11", 64'(regRdData), 64'd0);

    // R9: 25 updates at period 1, step 40<<18
    setInc(8'd1, 24'(40 << 18));
    loadTime(64'd0);
    idle(25);
    readTime("R9", t);
    chk("R9", t, 64'd25 * 64'(40 << 18));
    chk("R9", t >> 18, 64'd1000);

    // R10: 24 clocks at period 3, step 125<<14
    setInc(8'd3, 24'(125 << 14));
    loadTime(64'd0);
    idle(24);
    readTime("R10", t);
    chk("R10", t >> 14, 64'd1000);

    // R3: period 5, step 11, 17 clocks give 3 updates
    setInc(8'd5, 24'd11);
    loadTime(64'd100);
    idle(17);
    readTime("R3", t);
    chk("R3", t, 64'd133);

    // R4: period field zero adds every clock
    setInc(8'd0, 24'd7);
    loadTime(64'd0);
    idle(10);
    readTime("R4", t);
    chk("R4", t, 64'd70);

    // R5: change of configuration mid-period
    setInc(8'd4, 24'd5);
    loadTime(64'd0);
    idle(2);
    wr(2'd2, {8'd4, 24'd9});
    idle(5);
    readTime("R5", t);
    chk("R5", t, 64'd14);

    // R6: staging does not touch the count; high write loads both halves
    setInc(8'd1, 24'd0);
    loadTime(64'h0000_0007_0000_0003);
    wr(2'd0, 32'h0000_ABCD);
    rdReg("R6", 2'd0, v); chk("R6", 64'(v), 64'h3);
    wr(2'd1, 32'h0000_0009);
    readTime("R6", t);
    chk("R6", t, 64'h0000_0009_0000_ABCD);

    // R7: shadow keeps the high half across a carry
    setInc(8'd1, 24'd1);
    loadTime(64'h0000_0005_FFFF_FFFE);
    rdReg("R7", 2'd0, v); chk("R7", 64'(v), 64'hFFFF_FFFE);
    idle(5);
    rdReg("R7", 2'd1, v); chk("R7", 64'(v), 64'h5);

    // R8: wrap through 2^64
    setInc(8'd1, 24'h10);
    loadTime(64'hFFFF_FFFF_FFFF_FFF8);
    idle(1);
    readTime("R8", t);
    chk("R8", t, 64'h0000_0000_0000_0008);

    // Random mix checked against the reference state (R3 R5 R6 R7 R11)
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 8);
      case (op)
        0: wr(2'd2, {8'($urandom_range(0, 5)), 24'($urandom_range(0, 4095))});
        1: wr(2'd0, $urandom);
        2: wr(2'd1, $urandom_range(0, 3) == 0 ? 32'hFFFF_FFFF : $urandom);
        3: rdReg("R7", 2'd0, v);
        4: rdReg("R7", 2'd1, v);
        5: rdReg("R2", 2'd2, v);
        6: rdReg("R11", 2'd3, v);
        default: idle($urandom_range(1, 4));
      endcase
    end

    summary();
    $finish;
  end

endmodule